// File: doc/BRIEF.md
# Fast Address-Line-20 Gate Decoder

This block drives the gate signal that masks address line 20 for a host that expects old real-mode wrap-around behaviour. It sits beside the host-side write path of data channel 1 and watches every byte the host writes there. Each write is tagged as either a command or a data byte. When fast mode is enabled, a command byte of 0xD1 arms a small decoder, and the next data byte sets the gate from its bit 1. No firmware interrupt is involved. When fast mode is disabled, the pin simply follows a value that firmware writes.

Host writes arrive on a valid/ready stream. The block has no internal buffering and never pushes back. `wr_ready` is held high, and a byte is consumed on every rising clock edge where `wr_valid` is high. An upstream source may therefore present one byte per cycle, back to back, and may leave idle gaps of any length. The enable bit, the pin-direction bit and the firmware value are plain level inputs.

The gate state is a register that takes the value 1 at reset. It is held at 1 whenever fast mode is off, so each new enable starts with the gate open. The pin output is a combinational selection between that register and the firmware value. The output enable simply mirrors the direction bit.

Top module: `a20_gate_ctl`

## Requirements
- R1: After a synchronous active-low reset, the gate state is 1 and the decoder is disarmed. With fast mode enabled and no writes, `gate_out` reads 1.
- R2: `gate_oe` equals `pin_dir_out` in every cycle.
- R3: While `fast_en` is 0, `gate_out` equals `fw_gate` in the same cycle.
- R4: With `fast_en` at 1, an accepted write with `wr_is_cmd`=1 and `wr_byte`=0xD1 arms the decoder. The next accepted write with `wr_is_cmd`=0 loads bit 1 of `wr_byte` into the gate and disarms the decoder. The new value appears on `gate_out` in the cycle after that clock edge.
- R5: With `fast_en` at 1, an accepted command write of any value other than 0xD1 disarms the decoder and leaves the gate unchanged.
- R6: An accepted data write while the decoder is disarmed leaves the gate unchanged.
- R7: While `fast_en` is 0, the decoder is disarmed and the gate state is forced to 1, so the gate reads 1 in the first cycle after fast mode is re-enabled.
- R8: Writes accepted while `fast_en` is 0 neither arm the decoder nor change the gate.
- R9: `wr_ready` is always 1. Cycles with `wr_valid`=0 change nothing, so an armed decoder stays armed across idle gaps.
- R10: A repeated 0xD1 command while armed keeps the decoder armed. The following data byte still updates the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host write to channel 1 presented |
| wr_ready | output | 1 | Always 1; write accepted when valid |
| wr_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| wr_byte | input | 8 | Written byte |
| fast_en | input | 1 | Fast gate mode enable |
| pin_dir_out | input | 1 | Pin direction, 1 = output |
| fw_gate | input | 1 | Firmware-written gate value (regular mode) |
| gate_out | output | 1 | Gate pin value |
| gate_oe | output | 1 | Gate pin output enable |

## Verification
`gate_oe` and the regular-mode path through `fw_gate` are combinational, so they are due in the same cycle as their inputs. The arm flag and the gate state change on the edge that accepts a write, or on an edge where `fast_en` is low, so their effect on `gate_out` is due exactly one cycle later. The bench changes inputs just after a falling edge and updates its reference model on the rising edge from the same inputs. It compares `gate_out`, `gate_oe` and `wr_ready` at every falling edge, which places each comparison after all registered effects have settled and before the next stimulus.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;

  // Classification of one clock's host write activity.
  typedef enum logic [1:0] {
    EV_NONE      = 2'd0,
    EV_ARM       = 2'd1,
    EV_CMD_OTHER = 2'd2,
    EV_DATA      = 2'd3
  } a20_event_e;

  localparam int unsigned GATE_RESET_VAL = 1;

endpackage

// File: rtl/a20_event_classify.sv
module a20_event_classify
  import a20_gate_pkg::*;
#(
  parameter int unsigned        DATA_W   = 8,
  parameter logic [DATA_W-1:0]  ARM_CODE = 8'hD1
) (
  input  logic              beat,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              enable,
  output a20_event_e        event_o
);

  always_comb begin
    event_o = EV_NONE;
    if (beat && enable) begin
      if (!is_cmd) begin
        event_o = EV_DATA;
      end else if (byte_in == ARM_CODE) begin
        event_o = EV_ARM;
      end else begin
        event_o = EV_CMD_OTHER;
      end
    end
  end

endmodule

// File: rtl/a20_arm_tracker.sv
module a20_arm_tracker
  import a20_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  a20_event_e event_i,
  output logic       armed
);

  logic armed_nxt;

  always_comb begin
    armed_nxt = armed;
    if (!enable) begin
      armed_nxt = 1'b0;
    end else begin
      unique case (event_i)
        EV_ARM:       armed_nxt = 1'b1;
        EV_CMD_OTHER: armed_nxt = 1'b0;
        EV_DATA:      armed_nxt = 1'b0;
        default:      armed_nxt = armed;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_nxt;
  end

endmodule

// File: rtl/a20_gate_state.sv
module a20_gate_state
  import a20_gate_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              armed,
  input  a20_event_e        event_i,
  input  logic [DATA_W-1:0] byte_in,
  output logic              gate_q
);

  localparam logic RESET_BIT = 1'(GATE_RESET_VAL);

  logic gate_nxt;
  logic load;

  assign load = (event_i == EV_DATA) && armed;

  always_comb begin
    gate_nxt = gate_q;
    if (!enable)   gate_nxt = RESET_BIT;
    else if (load) gate_nxt = byte_in[GATE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= RESET_BIT;
    else        gate_q <= gate_nxt;
  end

endmodule

// File: rtl/a20_gate_ctl.sv
module a20_gate_ctl
  import a20_gate_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] ARM_CODE = 8'hD1,
  parameter int unsigned       GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_is_cmd,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              fast_en,
  input  logic              pin_dir_out,
  input  logic              fw_gate,
  output logic              gate_out,
  output logic              gate_oe
);

  a20_event_e ev;
  logic       armed;
  logic       gate_state;
  logic       beat;

  assign wr_ready = 1'b1;
  assign beat     = wr_valid && wr_ready;

  a20_event_classify #(
    .DATA_W   (DATA_W),
    .ARM_CODE (ARM_CODE)
  ) u_classify (
    .beat    (beat),
    .is_cmd  (wr_is_cmd),
    .byte_in (wr_byte),
    .enable  (fast_en),
    .event_o (ev)
  );

  a20_arm_tracker u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (fast_en),
    .event_i (ev),
    .armed   (armed)
  );

  a20_gate_state #(
    .DATA_W   (DATA_W),
    .GATE_BIT (GATE_BIT)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (fast_en),
    .armed   (armed),
    .event_i (ev),
    .byte_in (wr_byte),
    .gate_q  (gate_state)
  );

  assign gate_out = fast_en ? gate_state : fw_gate;
  assign gate_oe  = pin_dir_out;

endmodule

// File: rtl/a20_gate_chk.sv
module a20_gate_chk #(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] ARM_CODE = 8'hD1,
  parameter int unsigned       GATE_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_is_cmd,
  input logic [DATA_W-1:0] wr_byte,
  input logic              fast_en,
  input logic              pin_dir_out,
  input logic              fw_gate,
  input logic              gate_out,
  input logic              gate_oe,
  input logic              wr_ready,
  input logic              armed,
  input logic              gate_state
);

  assert_oe_mirrors_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_oe == pin_dir_out);

  assert_regular_follows_fw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |-> gate_out == fw_gate);

  assert_d1_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && wr_valid && wr_is_cmd && wr_byte == ARM_CODE) |=> armed);

  assert_data_loads_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && wr_valid && !wr_is_cmd && armed)
      |=> (!armed && gate_state == $past(wr_byte[GATE_BIT])));

  assert_other_cmd_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && wr_valid && wr_is_cmd && wr_byte != ARM_CODE)
      |=> (!armed && $stable(gate_state)));

  assert_unarmed_data_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && wr_valid && !wr_is_cmd && !armed) |=> (!armed && $stable(gate_state)));

  assert_disable_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> (!armed && gate_state));

  assert_always_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !wr_valid) |=> ($stable(armed) && $stable(gate_state)));

endmodule

bind a20_gate_ctl a20_gate_chk #(
  .DATA_W   (DATA_W),
  .ARM_CODE (ARM_CODE),
  .GATE_BIT (GATE_BIT)
) u_a20_gate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_is_cmd   (wr_is_cmd),
  .wr_byte     (wr_byte),
  .fast_en     (fast_en),
  .pin_dir_out (pin_dir_out),
  .fw_gate     (fw_gate),
  .gate_out    (gate_out),
  .gate_oe     (gate_oe),
  .wr_ready    (wr_ready),
  .armed       (armed),
  .gate_state  (gate_state)
);

// File: tb/test_a20_gate_ctl.sv
module test_a20_gate_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_is_cmd = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       fast_en = 1'b0;
  logic       pin_dir_out = 1'b0;
  logic       fw_gate = 1'b0;
  logic       wr_ready;
  logic       gate_out;
  logic       gate_oe;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  // Behavioural reference state
  bit m_gate = 1'b1;
  bit m_armed = 1'b0;

  always #5 clk = ~clk;

  a20_gate_ctl i_a20_gate_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_is_cmd   (wr_is_cmd),
    .wr_byte     (wr_byte),
    .fast_en     (fast_en),
    .pin_dir_out (pin_dir_out),
    .fw_gate     (fw_gate),
    .gate_out    (gate_out),
    .gate_oe     (gate_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate  <= 1'b1;
      m_armed <= 1'b0;
    end else if (!fast_en) begin
      m_gate  <= 1'b1;
      m_armed <= 1'b0;
    end else if (wr_valid) begin
      if (wr_is_cmd) begin
        m_armed <= (wr_byte == 8'hD1);
      end else if (m_armed) begin
        m_gate  <= wr_byte[1];
        m_armed <= 1'b0;
      end
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, tagged with the current phase
  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, "gate_out(model)", gate_out, fast_en ? m_gate : fw_gate);
      check("R2", "gate_oe", gate_oe, pin_dir_out);
      check("R9", "wr_ready", wr_ready, 1'b1);
    end
  end

  task automatic put(bit is_cmd, logic [7:0] b);
    @(negedge clk); #1;
    wr_valid = 1'b1; wr_is_cmd = is_cmd; wr_byte = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_valid = 1'b0; wr_byte = 8'h00;
    end
  endtask

  // Directed check at the next falling edge
  task automatic expect_gate(string req, logic exp);
    @(negedge clk);
    check(req, "gate_out", gate_out, exp);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); #1; rst_n = 1'b1; fast_en = 1'b1; pin_dir_out = 1'b1;
    // R1: reset value visible
    phase = "R1";
    expect_gate("R1", 1'b1);

    // R4: arm then data with bit1 = 0
    phase = "R4";
    put(1, 8'hD1); put(0, 8'hFD); idle(1);
    expect_gate("R4", 1'b0);
    put(1, 8'hD1); put(0, 8'h02); idle(1);
    expect_gate("R4", 1'b1);

    // R9: idle gap keeps armed
    phase = "R9";
    put(1, 8'hD1); idle(4); put(0, 8'h00); idle(1);
    expect_gate("R9", 1'b0);

    // R6: unarmed data ignored
    phase = "R6";
    put(0, 8'hFF); idle(1);
    expect_gate("R6", 1'b0);

    // R5: other command disarms, gate unchanged
    phase = "R5";
    put(1, 8'hD1); put(1, 8'hDD); idle(1);
    expect_gate("R5", 1'b0);
    put(0, 8'h02); idle(1);
    expect_gate("R5", 1'b0);

    // R10: repeated D1 stays armed
    phase = "R10";
    put(1, 8'hD1); put(1, 8'hD1); put(0, 8'h02); idle(1);
    expect_gate("R10", 1'b1);

    // R2: direction toggles
    phase = "R2";
    @(negedge clk); #1; pin_dir_out = 1'b0;
    @(negedge clk); check("R2", "gate_oe low", gate_oe, 1'b0);
    #1; pin_dir_out = 1'b1;

    // R3: regular mode follows firmware value
    phase = "R3";
    put(1, 8'hD1); put(0, 8'h00); idle(1);
    expect_gate("R4", 1'b0);
    @(negedge clk); #1; fast_en = 1'b0; fw_gate = 1'b1;
    @(negedge clk); check("R3", "fw high", gate_out, 1'b1);
    #1; fw_gate = 1'b0;
    @(negedge clk); check("R3", "fw low", gate_out, 1'b0);

    // R8: writes while disabled have no effect
    phase = "R8";
    put(1, 8'hD1); put(0, 8'h00); idle(1);
    @(negedge clk); #1; fast_en = 1'b1;
    @(negedge clk); check("R8", "gate after enable", gate_out, 1'b1);
    put(0, 8'h00); idle(1);
    expect_gate("R8", 1'b1);

    // R7: disable while armed disarms and restarts gate at 1
    phase = "R7";
    put(1, 8'hD1); put(0, 8'h00); idle(1);
    expect_gate("R7", 1'b0);
    put(1, 8'hD1); idle(1);
    @(negedge clk); #1; fast_en = 1'b0;
    @(negedge clk); #1; fast_en = 1'b1;
    @(negedge clk); check("R7", "gate after re-enable", gate_out, 1'b1);
    put(0, 8'h00); idle(1);
    expect_gate("R7", 1'b1);

    // R1: reset in the middle of an armed sequence
    phase = "R1";
    put(1, 8'hD1); put(0, 8'h00); put(1, 8'hD1); idle(1);
    @(negedge clk); #1; rst_n = 1'b0;
    @(negedge clk); #1; rst_n = 1'b1;
    @(negedge clk); check("R1", "gate after reset", gate_out, 1'b1);
    put(0, 8'h00); idle(1);
    expect_gate("R1", 1'b1);

    // Back-to-back mixed traffic
    phase = "R4";
    for (int k = 0; k < 40; k++) begin
      put(k[0], (k % 3 == 0) ? 8'hD1 : 8'(k * 37));
    end
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule